// File: doc/BRIEF.md
# NAND Controller Interrupt Status Unit

This unit gathers six event sources produced by a NAND flash controller and turns them into a single active-high, level-sensitive interrupt line. The sources are: flash device ready, controller ready, decode failure, decode error, ECC ready and write-protect fault. A rising edge on any source latches a sticky flag. A six-bit enable mask chooses which flags may raise the interrupt.

Software reads the flag register to learn why the line went high, and that same read clears every flag. A second read-only register shows the live level of the ready and ECC result inputs. That register uses a different bit order and includes the two-bit corrected-symbol count. Access goes through a simple synchronous register port. Read data appears on `rdata_o` one clock after the request and is held until the next read.

Top module: `nand_irq_ctrl`

## Requirements
- R1: After reset the enable mask and all flags are zero, `irq_o` is low and `rdata_o` is zero.
- R2: A rising edge on a source sets its flag. Flag and mask bit positions are: write-protect fault bit 0, ECC ready bit 1, decode error bit 2, decode failure bit 3, controller ready bit 4, flash ready bit 5. A source that is high when reset is released counts as a rising edge.
- R3: A flag stays set after its source falls, until the flag register is read.
- R4: `irq_o` is high exactly when some flag is set whose mask bit is set. It stays high with no further events until a clearing read.
- R5: The mask is written and read at address 0 in bits [5:0]. Bits above 5 read as zero.
- R6: A read of address 1 returns the flags in bits [5:0] and clears all of them in the same clock edge.
- R7: An event whose rising edge falls in the same cycle as a clearing read is absent from that read's data, and its flag remains set afterwards.
- R8: A read of address 2 returns the live inputs in this layout: flash ready bit 0, controller ready bit 1, ECC ready bit 2, errors detected bit 3, corrected count bits [5:4], decode failure bit 6.
- R9: The corrected count field passes `err_cnt_i` through unchanged. Its value is the number of corrected symbols minus one, so 0 with errors detected set means one correction.
- R10: Writes to addresses 1, 2 and 3 change no state, and a read of address 3 returns zero.
- R11: A source held high sets its flag once only. After a clearing read it does not set the flag again until it falls and rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid the cycle after a read |
| nand_rdy_i | input | 1 | Flash device ready level |
| ctrl_rdy_i | input | 1 | Controller ready level |
| ecc_rdy_i | input | 1 | ECC result ready level |
| dec_err_i | input | 1 | Decoder found correctable errors |
| dec_fail_i | input | 1 | Decoder failed to correct |
| err_cnt_i | input | 2 | Corrected symbols minus one |
| wp_fault_i | input | 1 | Write-protect fault |
| irq_o | output | 1 | Interrupt, active high level |

## Verification
The bench sweeps all 64 masks against all 64 event patterns. If the mask gating or the bit order were wrong, the interrupt would fire for a disabled flag or the flag read would show the wrong bit. An event that lands in the same cycle as a clearing read is the collision case. A design where the clear wins loses that event, and one that folds the event into the read data reports it twice. A source held high across a read tests for a level-sensitive capture, which would set the flag again at once. The live register is swept over all 128 input combinations so that any swapped field or reordered count bit shows up.

// File: rtl/nand_irq_pkg.sv
package nand_irq_pkg;
  localparam int NSRC = 6;
  // sticky flag / mask bit positions
  localparam int F_WP    = 0;
  localparam int F_ECC   = 1;
  localparam int F_DERR  = 2;
  localparam int F_DFAIL = 3;
  localparam int F_CTRL  = 4;
  localparam int F_NAND  = 5;
  // live status bit positions
  localparam int L_NAND  = 0;
  localparam int L_CTRL  = 1;
  localparam int L_ECC   = 2;
  localparam int L_ERR   = 3;
  localparam int L_CNT   = 4;
  localparam int CNT_W   = 2;
  localparam int L_FAIL  = 6;
  localparam int LIVE_W  = 7;

  typedef enum logic [1:0] {
    REG_MASK = 2'd0,
    REG_STAT = 2'd1,
    REG_LIVE = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/nand_irq_edge.sv
module nand_irq_edge #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[i] <= 1'b0;
      else         prev_q[i] <= lvl_i[i];
    end
    assign rise_o[i] = lvl_i[i] & ~prev_q[i];
  end
endmodule

// File: rtl/nand_irq_flags.sv
module nand_irq_flags #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flags_d;

  // set beats clear so a colliding event survives the read
  always_comb begin
    flags_d = clr_i ? '0 : flags_o;
    flags_d = flags_d | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= flags_d;
  end
endmodule

// File: rtl/nand_irq_live.sv
module nand_irq_live
  import nand_irq_pkg::*;
(
  input  logic             nand_rdy_i,
  input  logic             ctrl_rdy_i,
  input  logic             ecc_rdy_i,
  input  logic             dec_err_i,
  input  logic             dec_fail_i,
  input  logic [CNT_W-1:0] err_cnt_i,
  output logic [LIVE_W-1:0] live_o
);
  always_comb begin
    live_o                    = '0;
    live_o[L_NAND]            = nand_rdy_i;
    live_o[L_CTRL]            = ctrl_rdy_i;
    live_o[L_ECC]             = ecc_rdy_i;
    live_o[L_ERR]             = dec_err_i;
    live_o[L_CNT+:CNT_W]      = err_cnt_i;
    live_o[L_FAIL]            = dec_fail_i;
  end
endmodule

// File: rtl/nand_irq_ctrl.sv
module nand_irq_ctrl
  import nand_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              nand_rdy_i,
  input  logic              ctrl_rdy_i,
  input  logic              ecc_rdy_i,
  input  logic              dec_err_i,
  input  logic              dec_fail_i,
  input  logic [1:0]        err_cnt_i,
  input  logic              wp_fault_i,
  output logic              irq_o
);
  logic [NSRC-1:0]   lvl;
  logic [NSRC-1:0]   rise;
  logic [NSRC-1:0]   flags;
  logic [NSRC-1:0]   mask_q;
  logic [LIVE_W-1:0] live;
  logic              sel_mask, sel_stat, sel_live;
  logic              rd_en, wr_mask, rd_stat;
  logic [DATA_W-1:0] rdata_d;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:NSRC];

  always_comb begin
    lvl          = '0;
    lvl[F_WP]    = wp_fault_i;
    lvl[F_ECC]   = ecc_rdy_i;
    lvl[F_DERR]  = dec_err_i;
    lvl[F_DFAIL] = dec_fail_i;
    lvl[F_CTRL]  = ctrl_rdy_i;
    lvl[F_NAND]  = nand_rdy_i;
  end

  assign sel_mask = (addr_i == ADDR_W'(REG_MASK));
  assign sel_stat = (addr_i == ADDR_W'(REG_STAT));
  assign sel_live = (addr_i == ADDR_W'(REG_LIVE));
  assign rd_en    = req_i & ~we_i;
  assign wr_mask  = req_i & we_i & sel_mask;
  assign rd_stat  = rd_en & sel_stat;

  nand_irq_edge #(.W(NSRC)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl),
    .rise_o (rise)
  );

  nand_irq_flags #(.W(NSRC)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (rise),
    .clr_i   (rd_stat),
    .flags_o (flags)
  );

  nand_irq_live u_live (
    .nand_rdy_i (nand_rdy_i),
    .ctrl_rdy_i (ctrl_rdy_i),
    .ecc_rdy_i  (ecc_rdy_i),
    .dec_err_i  (dec_err_i),
    .dec_fail_i (dec_fail_i),
    .err_cnt_i  (err_cnt_i),
    .live_o     (live)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (wr_mask) mask_q <= wdata_i[NSRC-1:0];
  end

  always_comb begin
    rdata_d = '0;
    if (sel_mask)      rdata_d[NSRC-1:0]   = mask_q;
    else if (sel_stat) rdata_d[NSRC-1:0]   = flags;
    else if (sel_live) rdata_d[LIVE_W-1:0] = live;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (rd_en) rdata_o <= rdata_d;
  end

  assign irq_o = |(flags & mask_q);
endmodule

// File: rtl/nand_irq_chk.sv
module nand_irq_chk
  import nand_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic [NSRC-1:0]   rise,
  input logic [NSRC-1:0]   flags,
  input logic [NSRC-1:0]   mask_q
);
  logic rd_stat_c, wr_mask_c;
  assign rd_stat_c = req_i & ~we_i & (addr_i == ADDR_W'(REG_STAT));
  assign wr_mask_c = req_i & we_i & (addr_i == ADDR_W'(REG_MASK));

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      p_reset_r1: assert (!irq_o && flags == '0 && mask_q == '0 && rdata_o == '0);
    end
  end

  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise) |=> ((flags & $past(rise)) == $past(rise)));

  p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_stat_c |=> ((flags & $past(flags)) == $past(flags)));

  p_irq_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(|rise) || $past(wr_mask_c)));

  p_mask_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask_c |=> (mask_q == $past(wdata_i[NSRC-1:0])));

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_c && rise == '0) |=> (flags == '0 && !irq_o));

  p_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_c && |rise) |=> (flags == $past(rise)));

  p_mask_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mask_c |=> $stable(mask_q));
endmodule

bind nand_irq_ctrl nand_irq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .rise    (rise),
  .flags   (flags),
  .mask_q  (mask_q)
);

// File: tb/nand_irq_ctrl_bench.sv
module nand_irq_ctrl_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0;
  logic       we_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       nand_rdy_i = 1'b0, ctrl_rdy_i = 1'b0, ecc_rdy_i = 1'b0;
  logic       dec_err_i = 1'b0, dec_fail_i = 1'b0, wp_fault_i = 1'b0;
  logic [1:0] err_cnt_i = '0;
  logic       irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  nand_irq_ctrl u_nand_irq_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .nand_rdy_i(nand_rdy_i), .ctrl_rdy_i(ctrl_rdy_i), .ecc_rdy_i(ecc_rdy_i),
    .dec_err_i(dec_err_i), .dec_fail_i(dec_fail_i), .err_cnt_i(err_cnt_i),
    .wp_fault_i(wp_fault_i), .irq_o(irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // event pattern in flag order: 5 nand, 4 ctrl, 3 dfail, 2 derr, 1 ecc, 0 wp
  task automatic set_evt(input logic [5:0] e);
    nand_rdy_i = e[5]; ctrl_rdy_i = e[4]; dec_fail_i = e[3];
    dec_err_i  = e[2]; ecc_rdy_i  = e[1]; wp_fault_i = e[0];
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i); req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i); req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i); req_i = 1'b0; d = rdata_o;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 rdata", int'(rdata_o), 0);
    rst_ni = 1'b1;
    rd(2'd0, v); chk("R1 mask", v, 0);
    rd(2'd1, v); chk("R1 flags", v, 0);

    // R5 mask width
    wr(2'd0, 8'hFF); rd(2'd0, v); chk("R5 mask upper", v, 8'h3F);

    // R2 R3 R4 R6 exhaustive mask x event sweep
    for (int m = 0; m < 64; m++) begin
      wr(2'd0, 8'(m));
      for (int e = 0; e < 64; e++) begin
        @(negedge clk_i); set_evt(6'(e));
        @(negedge clk_i); set_evt(6'h0);
        chk("R4 irq", int'(irq_o), int'((e & m) != 0));
        @(negedge clk_i);
        chk("R3 irq held", int'(irq_o), int'((e & m) != 0));
        rd(2'd1, v); chk("R2 flags", v, e);
        chk("R6 irq clear", int'(irq_o), 0);
        if (e == 63) begin
          rd(2'd1, v); chk("R6 flags cleared", v, 0);
        end
      end
    end

    // R7 collision of event with clearing read
    wr(2'd0, 8'h3F);
    @(negedge clk_i); ctrl_rdy_i = 1'b1;
    @(negedge clk_i); ctrl_rdy_i = 1'b0;
    @(negedge clk_i); req_i = 1'b1; we_i = 1'b0; addr_i = 2'd1; nand_rdy_i = 1'b1;
    @(negedge clk_i); req_i = 1'b0; nand_rdy_i = 1'b0;
    chk("R7 read data", int'(rdata_o), 8'h10);
    chk("R7 irq kept", int'(irq_o), 1);
    rd(2'd1, v); chk("R7 flag kept", v, 8'h20);

    // R11 held level does not retrigger
    @(negedge clk_i); ecc_rdy_i = 1'b1;
    @(negedge clk_i);
    rd(2'd1, v); chk("R11 first", v, 8'h02);
    repeat (4) @(negedge clk_i);
    chk("R11 irq", int'(irq_o), 0);
    rd(2'd1, v); chk("R11 no retrigger", v, 0);
    @(negedge clk_i); ecc_rdy_i = 1'b0;
    @(negedge clk_i);

    // R10 writes to other addresses ignored, address 3 reads zero
    @(negedge clk_i); wp_fault_i = 1'b1;
    @(negedge clk_i); wp_fault_i = 1'b0;
    wr(2'd1, 8'h00); wr(2'd2, 8'hFF); wr(2'd3, 8'h00);
    chk("R10 irq", int'(irq_o), 1);
    rd(2'd0, v); chk("R10 mask", v, 8'h3F);
    rd(2'd3, v); chk("R10 addr3", v, 0);
    rd(2'd1, v); chk("R10 flags", v, 8'h01);

    // R8 R9 live status sweep: v = {fail, cnt[1:0], err, ecc, ctrl, nand}
    for (int s = 0; s < 128; s++) begin
      @(negedge clk_i);
      nand_rdy_i = s[0]; ctrl_rdy_i = s[1]; ecc_rdy_i = s[2];
      dec_err_i = s[3]; err_cnt_i = 2'(s >> 4); dec_fail_i = s[6];
      rd(2'd2, v); chk("R8 live", v, s);
      chk("R9 count", int'(v[5:4]), (s >> 4) & 3);
    end
    @(negedge clk_i); set_evt(6'h0); err_cnt_i = 2'd0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule